// File: doc/BRIEF.md
# Pipeline Data Hazard Detector

This block decides when the decode stage of a five-stage in-order pipeline must wait for an older instruction's result. Each cycle it receives the instruction sitting in decode: up to two source register numbers, each with a flag saying whether it is really read, plus the instruction's destination, a write flag and a load flag. It keeps its own copy of the destination, write and load bits for the three older instructions in execute, memory access and write-back. It raises a hold signal that freezes the program counter and the fetch/decode register. In the same cycle it raises a bubble signal that turns the next execute-stage entry into a no-op.

A mode input chooses between two policies and is evaluated every cycle. With forwarding enabled, only a load followed at once by a reader of its destination waits, and it waits one cycle. With forwarding disabled, decode waits while any of the three tracked older instructions will still write a register that decode reads. The stall ends only once that producer has moved past write-back. The forwarding paths, the register file and the datapath are built elsewhere.

Top module: `pipe_hazard_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all tracked stages are empty, so hold_o and bubble_o are low even when decode holds a valid instruction that reads registers.
- R2: With fwd_en = 1, an instruction in decode that reads the destination of a load directly in front of it is held for exactly one cycle. A load two or more places ahead causes no hold.
- R3: With fwd_en = 1, a non-load producer (id_mem_load = 0) never causes a hold, even for the very next instruction.
- R4: With fwd_en = 0, a reader of a register written by the instruction 1, 2 or 3 places ahead of it is held for 3, 2 or 1 cycles respectively. The hold is renewed each cycle until the producer has left write-back. A producer 4 or more places ahead causes no hold. Inserted bubbles write nothing.
- R5: A destination of register 0 never causes a hold in either mode.
- R6: A source whose enable flag (id_rs_a_en or id_rs_b_en) is 0 never causes a hold, whatever register number it carries.
- R7: Write-after-read and write-after-write pairs never cause a hold: matching the producer's destination with the consumer's destination, or the producer's source with the consumer's destination, has no effect.
- R8: bubble_o equals hold_o in every cycle. Both are low in any cycle where id_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fwd_en | input | 1 | 1: forwarding policy, 0: no-forwarding policy |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_rs_a | input | 5 | First source register number |
| id_rs_a_en | input | 1 | First source is read |
| id_rs_b | input | 5 | Second source register number |
| id_rs_b_en | input | 1 | Second source is read |
| id_rd | input | 5 | Destination register number |
| id_rd_we | input | 1 | Instruction writes its destination |
| id_mem_load | input | 1 | Instruction is a memory load |
| hold_o | output | 1 | Freeze program counter and fetch/decode register |
| bubble_o | output | 1 | Load a no-op into the decode/execute register |

## Verification
The tracked stages are invisible at the ports except through hold_o. A corrupted entry therefore shows up as a wrong stall length on some later instruction in decode. If a tracked entry gets the wrong destination or write bit, or shifts incorrectly, the stall count changes within one to three cycles of the affected producer, when its consumer reaches decode. A bubble that wrongly keeps a write bit shows up as extra hold cycles on the next dependent reader. The bench therefore compares the hold length of every instruction against an issue-time model, using both directed dependence distances and long random streams in each mode.

// File: rtl/hz_pkg.sv
`timescale 1ns/1ps
package hz_pkg;

  // Policy selected by the mode input
  typedef enum logic {
    HZ_MODE_NOFWD = 1'b0,
    HZ_MODE_FWD   = 1'b1
  } hz_mode_e;

  // Default geometry: 32 architectural registers, three stages tracked
  localparam int unsigned HZ_REG_AW = 5;
  localparam int unsigned HZ_DEPTH  = 3;

endpackage

// File: rtl/hz_track.sv
`timescale 1ns/1ps
// Shift register of producer metadata for the stages behind decode.
// Entry 0 is execute, entry DEPTH-1 is the oldest tracked stage.
module hz_track #(
  parameter int unsigned REG_AW = 5,
  parameter int unsigned DEPTH  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap_valid_i,
  input  logic                    cap_we_i,
  input  logic                    cap_ld_i,
  input  logic [REG_AW-1:0]       cap_rd_i,
  output logic [DEPTH-1:0]        we_o,
  output logic [DEPTH-1:0]        ld_o,
  output logic [DEPTH*REG_AW-1:0] rd_o
);

  logic [DEPTH-1:0]        we_q, we_d;
  logic [DEPTH-1:0]        ld_q, ld_d;
  logic [DEPTH*REG_AW-1:0] rd_q, rd_d;

  // Next state: capture decode (or a bubble) into entry 0, shift the rest
  always_comb begin
    we_d[0]          = cap_valid_i & cap_we_i & (cap_rd_i != '0);
    ld_d[0]          = cap_valid_i & cap_ld_i;
    rd_d[REG_AW-1:0] = cap_valid_i ? cap_rd_i : '0;
    for (int j = 1; j < DEPTH; j++) begin
      we_d[j]                 = we_q[j-1];
      ld_d[j]                 = ld_q[j-1];
      rd_d[j*REG_AW +: REG_AW] = rd_q[(j-1)*REG_AW +: REG_AW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= '0;
      ld_q <= '0;
      rd_q <= '0;
    end else begin
      we_q <= we_d;
      ld_q <= ld_d;
      rd_q <= rd_d;
    end
  end

  assign we_o = we_q;
  assign ld_o = ld_q;
  assign rd_o = rd_q;

  // A tracked writer never names register 0
  AST_NO_ZERO_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    we_q[0] |=> (rd_q[REG_AW +: REG_AW] != '0)); // R5

endmodule

// File: rtl/hz_cmp.sv
`timescale 1ns/1ps
// Compares one tracked producer against the two decode sources.
module hz_cmp #(
  parameter int unsigned REG_AW = 5
) (
  input  logic              stage_en_i,
  input  logic              need_load_i,
  input  logic              prod_we_i,
  input  logic              prod_ld_i,
  input  logic [REG_AW-1:0] prod_rd_i,
  input  logic [REG_AW-1:0] src_a_i,
  input  logic              src_a_en_i,
  input  logic [REG_AW-1:0] src_b_i,
  input  logic              src_b_en_i,
  output logic              hit_o
);

  logic match_a, match_b;

  always_comb begin
    match_a = src_a_en_i & (src_a_i != '0) & (src_a_i == prod_rd_i);
    match_b = src_b_en_i & (src_b_i != '0) & (src_b_i == prod_rd_i);
    hit_o   = stage_en_i & prod_we_i & (match_a | match_b) &
              (~need_load_i | prod_ld_i);
  end

endmodule

// File: rtl/pipe_hazard_unit.sv
`timescale 1ns/1ps
module pipe_hazard_unit #(
  parameter int unsigned REG_AW = hz_pkg::HZ_REG_AW,
  parameter int unsigned DEPTH  = hz_pkg::HZ_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fwd_en,
  input  logic              id_valid,
  input  logic [REG_AW-1:0] id_rs_a,
  input  logic              id_rs_a_en,
  input  logic [REG_AW-1:0] id_rs_b,
  input  logic              id_rs_b_en,
  input  logic [REG_AW-1:0] id_rd,
  input  logic              id_rd_we,
  input  logic              id_mem_load,
  output logic              hold_o,
  output logic              bubble_o
);

  import hz_pkg::*;

  localparam int unsigned RUN_W = $clog2(DEPTH + 2);

  hz_mode_e                mode;
  logic [DEPTH-1:0]        trk_we, trk_ld, hit;
  logic [DEPTH*REG_AW-1:0] trk_rd;
  logic                    stall;

  assign mode = hz_mode_e'(fwd_en);

  hz_track #(.REG_AW(REG_AW), .DEPTH(DEPTH)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_valid_i (id_valid & ~stall),
    .cap_we_i    (id_rd_we),
    .cap_ld_i    (id_mem_load),
    .cap_rd_i    (id_rd),
    .we_o        (trk_we),
    .ld_o        (trk_ld),
    .rd_o        (trk_rd)
  );

  // Forwarding: only execute entry, and only loads. Otherwise: whole window.
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    hz_cmp #(.REG_AW(REG_AW)) u_cmp (
      .stage_en_i  ((mode == HZ_MODE_NOFWD) || (g == 0)),
      .need_load_i (mode == HZ_MODE_FWD),
      .prod_we_i   (trk_we[g]),
      .prod_ld_i   (trk_ld[g]),
      .prod_rd_i   (trk_rd[g*REG_AW +: REG_AW]),
      .src_a_i     (id_rs_a),
      .src_a_en_i  (id_rs_a_en),
      .src_b_i     (id_rs_b),
      .src_b_en_i  (id_rs_b_en),
      .hit_o       (hit[g])
    );
  end

  assign stall    = id_valid & (|hit);
  assign hold_o   = stall;
  assign bubble_o = stall;

  // Consecutive-hold counter, used only by the window check below
  logic [RUN_W-1:0] run_q, run_d;

  always_comb begin
    run_d = run_q;
    if (!stall)
      run_d = '0;
    else if (run_q != {RUN_W{1'b1}})
      run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  AST_FWD_SINGLE_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_o && fwd_en) |=> !(hold_o && fwd_en)); // R2

  AST_HOLD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_W'(DEPTH)); // R4

  AST_BUBBLE_CLEARS_WE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_o |=> !trk_we[0]); // R4

  AST_SRC_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    hold_o |-> ((id_rs_a_en && id_rs_a != '0) || (id_rs_b_en && id_rs_b != '0))); // R6

endmodule

// File: tb/pipe_hazard_unit_bench.sv
`timescale 1ns/1ps
module pipe_hazard_unit_bench;

  logic       clk;
  logic       rst_n;
  logic       fwd_en;
  logic       id_valid;
  logic [4:0] id_rs_a, id_rs_b, id_rd;
  logic       id_rs_a_en, id_rs_b_en, id_rd_we, id_mem_load;
  logic       hold_o, bubble_o;

  pipe_hazard_unit u_pipe_hazard_unit (
    .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en), .id_valid(id_valid),
    .id_rs_a(id_rs_a), .id_rs_a_en(id_rs_a_en),
    .id_rs_b(id_rs_b), .id_rs_b_en(id_rs_b_en),
    .id_rd(id_rd), .id_rd_we(id_rd_we), .id_mem_load(id_mem_load),
    .hold_o(hold_o), .bubble_o(bubble_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  int    exp_q[$];
  string req_q[$];

  // Issue-time model: earliest decode slot for each instruction
  int       t_last;
  int       h_t[3];
  bit [4:0] h_rd[3];
  bit       h_we[3];
  bit       h_ld[3];

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic idle();
    @(posedge clk); #1;
    id_valid = 1'b0;
    t_last++;
    @(negedge clk);
  endtask

  task automatic issue(input bit [4:0] ra, input bit ea, input bit [4:0] rb, input bit eb,
                       input bit [4:0] rd, input bit we, input bit ld, input string req);
    int earliest, tgt;
    earliest = t_last + 1;
    tgt      = earliest;
    for (int j = 0; j < 3; j++) begin
      if (h_we[j] && h_rd[j] != 0 && ((ea && ra == h_rd[j]) || (eb && rb == h_rd[j]))) begin
        if (fwd_en) begin
          if (h_ld[j] && h_t[j] + 2 > tgt) tgt = h_t[j] + 2;
        end else if (h_t[j] + 4 > tgt) begin
          tgt = h_t[j] + 4;
        end
      end
    end
    for (int j = 2; j > 0; j--) begin
      h_t[j] = h_t[j-1]; h_rd[j] = h_rd[j-1]; h_we[j] = h_we[j-1]; h_ld[j] = h_ld[j-1];
    end
    h_t[0] = tgt; h_rd[0] = rd; h_we[0] = we; h_ld[0] = ld;
    t_last = tgt;
    @(posedge clk); #1;
    exp_q.push_back(tgt - earliest);
    req_q.push_back(req);
    id_valid = 1'b1;
    id_rs_a = ra; id_rs_a_en = ea; id_rs_b = rb; id_rs_b_en = eb;
    id_rd = rd; id_rd_we = we; id_mem_load = ld;
    forever begin
      @(negedge clk);
      if (hold_o !== 1'b1) break;
    end
  endtask

  // Monitor: counts hold cycles per instruction and compares with the queue
  int stall_cnt = 0;
  bit bub_bad   = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!id_valid) begin
        check(hold_o === 1'b0 && bubble_o === 1'b0, "R8", int'(hold_o), 0);
      end else begin
        if (bubble_o !== hold_o) bub_bad = 1;
        if (hold_o === 1'b1) begin
          stall_cnt++;
        end else if (exp_q.size() > 0) begin
          int    e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          check(stall_cnt == e, r, stall_cnt, e);
          check(!bub_bad, "R8", int'(bub_bad), 0);
          stall_cnt = 0;
          bub_bad   = 0;
        end
      end
    end
  end

  task automatic drain();
    for (int k = 0; k < 4; k++) idle();
  endtask

  task automatic random_run(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      if ($urandom_range(0, 7) == 0) idle();
      else issue(5'($urandom_range(0, 7)), $urandom_range(0, 3) != 0,
                 5'($urandom_range(0, 7)), $urandom_range(0, 3) != 0,
                 5'($urandom_range(0, 7)), $urandom_range(0, 3) != 0,
                 $urandom_range(0, 2) == 0, req);
    end
  endtask

  initial begin
    #2_000_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_last = 0;
    for (int j = 0; j < 3; j++) begin
      h_t[j] = -100; h_rd[j] = 0; h_we[j] = 0; h_ld[j] = 0;
    end
    rst_n = 1'b0; fwd_en = 1'b1;
    id_valid = 1'b1; id_rs_a = 5'd1; id_rs_a_en = 1'b1; id_rs_b = 5'd2; id_rs_b_en = 1'b1;
    id_rd = 5'd1; id_rd_we = 1'b1; id_mem_load = 1'b1;
    repeat (3) @(negedge clk);
    // R1: nothing tracked during reset
    check(hold_o === 1'b0 && bubble_o === 1'b0, "R1", int'(hold_o), 0);
    @(posedge clk); #1;
    id_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check(hold_o === 1'b0, "R1", int'(hold_o), 0);
    drain();

    // Forwarding policy, directed
    fwd_en = 1'b1;
    issue(5'd2, 1, 5'd3, 1, 5'd1, 1, 0, "R1");      // first instruction after reset
    issue(5'd1, 1, 5'd0, 0, 5'd5, 1, 0, "R3");      // ALU result used next: no hold
    issue(5'd9, 1, 5'd0, 0, 5'd4, 1, 1, "R2");      // load r4
    issue(5'd6, 1, 5'd4, 1, 5'd7, 1, 0, "R2");      // reads r4 next: one hold
    issue(5'd9, 1, 5'd0, 0, 5'd4, 1, 1, "R2");      // load r4
    issue(5'd6, 1, 5'd0, 0, 5'd8, 1, 0, "R2");      // unrelated
    issue(5'd4, 1, 5'd0, 0, 5'd8, 1, 0, "R2");      // two behind: no hold
    issue(5'd1, 1, 5'd0, 0, 5'd0, 1, 1, "R5");      // load to r0
    issue(5'd0, 1, 5'd0, 1, 5'd3, 1, 0, "R5");      // reads r0: no hold
    issue(5'd1, 1, 5'd0, 0, 5'd7, 1, 1, "R6");      // load r7
    issue(5'd7, 0, 5'd7, 0, 5'd3, 1, 0, "R6");      // r7 named but not read
    issue(5'd9, 1, 5'd0, 0, 5'd8, 1, 1, "R7");      // load r8 from r9
    issue(5'd10, 1, 5'd0, 0, 5'd8, 1, 0, "R7");     // WAW on r8
    issue(5'd11, 1, 5'd0, 0, 5'd9, 1, 1, "R7");     // load writing r9
    issue(5'd12, 1, 5'd0, 0, 5'd11, 1, 0, "R7");    // WAR on r11
    drain();

    // No-forwarding policy, directed
    fwd_en = 1'b0;
    issue(5'd2, 1, 5'd0, 0, 5'd1, 1, 0, "R4");
    issue(5'd1, 1, 5'd0, 0, 5'd20, 1, 0, "R4");     // distance 1: three holds
    drain();
    issue(5'd2, 1, 5'd0, 0, 5'd2, 1, 0, "R4");
    issue(5'd5, 1, 5'd0, 0, 5'd0, 0, 0, "R4");
    issue(5'd0, 0, 5'd2, 1, 5'd21, 1, 0, "R4");     // distance 2: two holds
    drain();
    issue(5'd4, 1, 5'd0, 0, 5'd3, 1, 1, "R4");
    issue(5'd5, 1, 5'd0, 0, 5'd0, 0, 0, "R4");
    issue(5'd5, 1, 5'd0, 0, 5'd0, 0, 0, "R4");
    issue(5'd3, 1, 5'd0, 0, 5'd22, 1, 0, "R4");     // distance 3: one hold
    drain();
    issue(5'd4, 1, 5'd0, 0, 5'd3, 1, 0, "R4");
    for (int k = 0; k < 3; k++) issue(5'd5, 1, 5'd0, 0, 5'd0, 0, 0, "R4");
    issue(5'd3, 1, 5'd0, 0, 5'd22, 1, 0, "R4");     // distance 4: no hold
    issue(5'd1, 1, 5'd0, 0, 5'd0, 1, 0, "R5");      // writes r0
    issue(5'd0, 1, 5'd0, 1, 5'd6, 1, 0, "R5");
    issue(5'd13, 1, 5'd0, 0, 5'd14, 1, 0, "R7");
    issue(5'd15, 1, 5'd0, 0, 5'd14, 1, 0, "R7");    // WAW
    issue(5'd16, 1, 5'd0, 0, 5'd13, 1, 0, "R7");    // WAR
    issue(5'd14, 0, 5'd14, 0, 5'd17, 1, 0, "R6");   // r14 named, unread
    drain();

    // Random streams in both policies
    fwd_en = 1'b1;
    random_run(400, "R2");
    drain();
    fwd_en = 1'b0;
    random_run(400, "R4");
    drain();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule